// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Segment Decode

This block translates 32-bit virtual addresses for a processor that refills its translation cache in software. Every lookup carries a 6-bit address-space number next to the address. Because each stored entry carries the same kind of tag, mappings from up to 64 processes can stay in the buffer at once, and a context switch needs no flush. The 64 entries are fully associative and are all compared in parallel in the lookup cycle.

The three top address bits select a segment. User addresses (top bit 0) and the upper kernel region (top bits 11) go through the buffer. The two middle kernel regions (top bits 100 and 101) bypass it: they map straight onto physical memory, the first as cacheable and the second as uncacheable. When a translated lookup finds no entry, a miss fault is raised and a software handler refills the buffer. It writes an entry through a write port, and a free-running pseudo-random index is available to choose the entry to replace. Stores to pages that are not marked writeable raise a modify fault. User-mode references to any kernel segment raise an address error.

Lookup is combinational: the outputs follow the address and mode inputs in the same cycle. Entry writes take effect at the next clock edge.

Top module: `seg_tlb`

## Requirements
- R1: After reset every entry is invalid, so any translated lookup misses, and `randIdx` equals 1.
- R2: Segment decode on `lookupVa[31:29]`: 0xx is user (translated), 100 is kernel direct cached, 101 is kernel direct uncached, 11x is kernel mapped (translated).
- R3: A kernel-mode lookup in a direct segment gives `physAddr` equal to `lookupVa` with bits 31..29 cleared, and no fault, whatever the buffer holds. `cacheable` is 1 for 100 and 0 for 101.
- R4: An entry matches when it is valid, its page number equals `lookupVa[31:12]`, and either its global bit is set or its space tag equals `curAsid`. A hit gives `physAddr = {frame, lookupVa[11:0]}` and `cacheable = !noCache` of that entry.
- R5: A translated lookup with no matching entry raises `tlbMiss`, and drives `physAddr` to 0 and `cacheable` to 0.
- R6: A store (`isStore`=1) that hits an entry whose writeable bit is 0 raises `modFault`, with `physAddr` 0 and `cacheable` 0. A load to the same entry translates normally.
- R7: With `userMode`=1, any address with bit 31 set raises `addrErr`, with `physAddr` 0 and `cacheable` 0.
- R8: When `wrEn`=1 at a clock edge, entry `wrIdx` takes all the `wr*` fields and replaces its previous contents. The new contents are used from the next cycle on.
- R9: `randIdx` is a 6-bit shift register that never reads 0. Each cycle out of reset it becomes `{r[4:0], r[5]^r[4]}`.
- R10: At most one fault is raised at a time. `addrErr` takes precedence over `tlbMiss`, and `tlbMiss` takes precedence over `modFault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupVa | input | 32 | Virtual address to translate |
| curAsid | input | 6 | Address-space number of the running process |
| isStore | input | 1 | 1 for a store, 0 for a load or fetch |
| userMode | input | 1 | 1 when the reference is made in user mode |
| wrEn | input | 1 | Write one entry at the next edge |
| wrIdx | input | 6 | Entry number to write |
| wrValid | input | 1 | Valid bit for the written entry |
| wrGlobal | input | 1 | Global bit: the entry matches any space number |
| wrDirty | input | 1 | Writeable bit for the written entry |
| wrNoCache | input | 1 | Non-cacheable bit for the written entry |
| wrAsid | input | 6 | Space tag for the written entry |
| wrVpn | input | 20 | Virtual page number for the written entry |
| wrPfn | input | 20 | Physical frame number for the written entry |
| physAddr | output | 32 | Translated physical address, 0 when a fault is raised |
| cacheable | output | 1 | Reference may be cached |
| tlbMiss | output | 1 | Translated lookup found no entry |
| modFault | output | 1 | Store to a page that is not writeable |
| addrErr | output | 1 | User-mode reference to a kernel segment |
| randIdx | output | 6 | Pseudo-random entry number for replacement |

## Verification
The assertions assume that software never leaves two valid entries that match the same page and space number, since a double match has no defined result. They also assume that the write inputs stay idle while reset is asserted. The bench keeps to the first rule by tying the low six bits of every written page number to the entry number it is written into, so no two entries can hold the same page. It drives no write until reset is released. Random lookups draw their page numbers from the same small pool, so hits, misses, global matches and space-number mismatches all occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    SEG_USER    = 2'd0,
    SEG_DIRECTC = 2'd1,
    SEG_DIRECTU = 2'd2,
    SEG_KMAPPED = 2'd3
  } segKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrStrobe;     // commit the write fields into the addressed entry
    logic useXlate;     // drive the translated address
    logic bypass;       // drive the direct-mapped address
    logic bypassCached; // attribute of the direct region
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       vaTop,
  input  logic             userMode,
  input  logic             isStore,
  input  logic             wrEn,
  input  logic             hitAny,
  input  logic             hitDirty,
  output tlbStrobe_t       strobe,
  output logic             tlbMiss,
  output logic             modFault,
  output logic             addrErr,
  output logic [IDX_W-1:0] randIdx
);

  // feedback taps of a maximal-length shift register, picked by width
  localparam logic [IDX_W-1:0] TAP_MASK =
      (IDX_W == 3) ? IDX_W'(3'b110) :
      (IDX_W == 4) ? IDX_W'(4'b1100) :
      (IDX_W == 5) ? IDX_W'(5'b10100) :
      (IDX_W == 6) ? IDX_W'(6'b110000) :
      (IDX_W == 7) ? IDX_W'(7'b1100000) :
      (IDX_W == 8) ? IDX_W'(8'b10111000) :
                     IDX_W'(2'b11) << (IDX_W - 2);

  segKind_e seg;
  logic     translated;

  always_comb begin
    unique casez (vaTop)
      3'b0??:  seg = SEG_USER;
      3'b100:  seg = SEG_DIRECTC;
      3'b101:  seg = SEG_DIRECTU;
      default: seg = SEG_KMAPPED;
    endcase
  end

  assign translated = (seg == SEG_USER) || (seg == SEG_KMAPPED);
  assign addrErr    = userMode && (seg != SEG_USER);
  assign tlbMiss    = !addrErr && translated && !hitAny;
  assign modFault   = !addrErr && translated && hitAny && isStore && !hitDirty;

  always_comb begin
    strobe.wrStrobe     = wrEn;
    strobe.useXlate     = translated && !addrErr && !tlbMiss && !modFault;
    strobe.bypass       = !translated && !addrErr;
    strobe.bypassCached = (seg == SEG_DIRECTC);
  end

  logic [IDX_W-1:0] lfsrQ;
  logic             feedBit;

  assign feedBit = ^(lfsrQ & TAP_MASK);

  always_ff @(posedge clk) begin
    if (!rstN) lfsrQ <= IDX_W'(1);
    else       lfsrQ <= {lfsrQ[IDX_W-2:0], feedBit};
  end

  assign randIdx = lfsrQ;

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 6,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 6,
  parameter int VPN_W   = VA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tlbStrobe_t        strobe,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic              wrDirty,
  input  logic              wrNoCache,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [VPN_W-1:0]  wrPfn,
  output logic              hitAny,
  output logic              hitDirty,
  output logic [VA_W-1:0]   physAddr,
  output logic              cacheable
);

  logic              entValid   [ENTRIES];
  logic              entGlobal  [ENTRIES];
  logic              entDirty   [ENTRIES];
  logic              entNoCache [ENTRIES];
  logic [ASID_W-1:0] entAsid    [ENTRIES];
  logic [VPN_W-1:0]  entVpn     [ENTRIES];
  logic [VPN_W-1:0]  entPfn     [ENTRIES];
  logic [ENTRIES-1:0] matchVec;

  logic [VPN_W-1:0] lookVpn;
  assign lookVpn = va[VA_W-1:OFF_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic wrHere;
    assign wrHere = strobe.wrStrobe && (wrIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[e]   <= 1'b0;
        entGlobal[e]  <= 1'b0;
        entDirty[e]   <= 1'b0;
        entNoCache[e] <= 1'b0;
        entAsid[e]    <= '0;
        entVpn[e]     <= '0;
        entPfn[e]     <= '0;
      end else if (wrHere) begin
        entValid[e]   <= wrValid;
        entGlobal[e]  <= wrGlobal;
        entDirty[e]   <= wrDirty;
        entNoCache[e] <= wrNoCache;
        entAsid[e]    <= wrAsid;
        entVpn[e]     <= wrVpn;
        entPfn[e]     <= wrPfn;
      end
    end

    assign matchVec[e] = entValid[e] && (entVpn[e] == lookVpn) &&
                         (entGlobal[e] || (entAsid[e] == curAsid));
  end

  // lowest matching entry wins
  logic [VPN_W-1:0] selPfn;
  logic             selNoCache;
  logic             selDirty;

  always_comb begin
    selPfn     = '0;
    selNoCache = 1'b0;
    selDirty   = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (matchVec[e]) begin
        selPfn     = entPfn[e];
        selNoCache = entNoCache[e];
        selDirty   = entDirty[e];
      end
    end
  end

  assign hitAny   = |matchVec;
  assign hitDirty = selDirty;

  logic [VA_W-1:0] directPa;
  assign directPa = {3'b000, va[VA_W-4:0]};

  always_comb begin
    if (strobe.useXlate) begin
      physAddr  = {selPfn, va[OFF_W-1:0]};
      cacheable = !selNoCache;
    end else if (strobe.bypass) begin
      physAddr  = directPa;
      cacheable = strobe.bypassCached;
    end else begin
      physAddr  = '0;
      cacheable = 1'b0;
    end
  end

endmodule

// File: rtl/seg_tlb.sv
module seg_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 6,
  parameter int OFF_W   = 12,
  localparam int VA_W   = 32,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [VA_W-1:0]   lookupVa,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              isStore,
  input  logic              userMode,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic              wrGlobal,
  input  logic              wrDirty,
  input  logic              wrNoCache,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [VPN_W-1:0]  wrPfn,
  output logic [VA_W-1:0]   physAddr,
  output logic              cacheable,
  output logic              tlbMiss,
  output logic              modFault,
  output logic              addrErr,
  output logic [IDX_W-1:0]  randIdx
);

  tlbStrobe_t strobe;
  logic       hitAny;
  logic       hitDirty;

  tlb_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .vaTop    (lookupVa[VA_W-1:VA_W-3]),
    .userMode (userMode),
    .isStore  (isStore),
    .wrEn     (wrEn),
    .hitAny   (hitAny),
    .hitDirty (hitDirty),
    .strobe   (strobe),
    .tlbMiss  (tlbMiss),
    .modFault (modFault),
    .addrErr  (addrErr),
    .randIdx  (randIdx)
  );

  tlb_datapath #(
    .ENTRIES (ENTRIES),
    .ASID_W  (ASID_W),
    .VA_W    (VA_W),
    .OFF_W   (OFF_W),
    .IDX_W   (IDX_W),
    .VPN_W   (VPN_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .va        (lookupVa),
    .curAsid   (curAsid),
    .wrIdx     (wrIdx),
    .wrValid   (wrValid),
    .wrGlobal  (wrGlobal),
    .wrDirty   (wrDirty),
    .wrNoCache (wrNoCache),
    .wrAsid    (wrAsid),
    .wrVpn     (wrVpn),
    .wrPfn     (wrPfn),
    .hitAny    (hitAny),
    .hitDirty  (hitDirty),
    .physAddr  (physAddr),
    .cacheable (cacheable)
  );

endmodule

// File: rtl/seg_tlb_chk.sv
module seg_tlb_chk #(
  parameter int ASID_W = 6,
  parameter int VPN_W  = 20,
  parameter int IDX_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [31:0]       lookupVa,
  input logic [ASID_W-1:0] curAsid,
  input logic              userMode,
  input logic              wrEn,
  input logic              wrValid,
  input logic              wrGlobal,
  input logic [ASID_W-1:0] wrAsid,
  input logic [VPN_W-1:0]  wrVpn,
  input logic [31:0]       physAddr,
  input logic              cacheable,
  input logic              tlbMiss,
  input logic              modFault,
  input logic              addrErr,
  input logic [IDX_W-1:0]  randIdx
);

  logic inXlateSeg;
  assign inXlateSeg = !lookupVa[31] || (lookupVa[31:30] == 2'b11);

  // R3: direct regions bypass the buffer
  assert_direct_map_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!userMode && lookupVa[31:30] == 2'b10) |->
      (physAddr == {3'b000, lookupVa[28:0]}) && (cacheable == !lookupVa[29]) &&
      !tlbMiss && !modFault && !addrErr);

  // R7: user references to kernel segments
  assert_user_kernel_R7: assert property (@(posedge clk) disable iff (!rstN)
    (userMode && lookupVa[31]) |-> addrErr && !tlbMiss && !modFault &&
      (physAddr == '0) && !cacheable);

  // R10: single fault at a time
  assert_one_fault_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tlbMiss, modFault, addrErr}));

  // R5, R6: a faulting lookup drives no address
  assert_fault_blank_R5: assert property (@(posedge clk) disable iff (!rstN)
    (tlbMiss || modFault) |-> (physAddr == '0) && !cacheable);

  // R9: replacement index never zero and always moving
  assert_rand_nonzero_R9: assert property (@(posedge clk) disable iff (!rstN)
    randIdx != '0);
  assert_rand_moves_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> randIdx != $past(randIdx));

  // R8: an entry just written matches on the next cycle
  assert_write_visible_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && $past(wrValid) &&
     lookupVa[31:12] == $past(wrVpn) &&
     ($past(wrGlobal) || curAsid == $past(wrAsid)) &&
     inXlateSeg && !(userMode && lookupVa[31])) |-> !tlbMiss);

endmodule

bind seg_tlb seg_tlb_chk #(.ASID_W(ASID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .lookupVa  (lookupVa),
  .curAsid   (curAsid),
  .userMode  (userMode),
  .wrEn      (wrEn),
  .wrValid   (wrValid),
  .wrGlobal  (wrGlobal),
  .wrAsid    (wrAsid),
  .wrVpn     (wrVpn),
  .physAddr  (physAddr),
  .cacheable (cacheable),
  .tlbMiss   (tlbMiss),
  .modFault  (modFault),
  .addrErr   (addrErr),
  .randIdx   (randIdx)
);

// File: tb/seg_tlb_test.sv
`timescale 1ns/1ps
module seg_tlb_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupVa = '0;
  logic [5:0]  curAsid = '0;
  logic        isStore = 1'b0;
  logic        userMode = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic        wrValid = 1'b0;
  logic        wrGlobal = 1'b0;
  logic        wrDirty = 1'b0;
  logic        wrNoCache = 1'b0;
  logic [5:0]  wrAsid = '0;
  logic [19:0] wrVpn = '0;
  logic [19:0] wrPfn = '0;
  logic [31:0] physAddr;
  logic        cacheable, tlbMiss, modFault, addrErr;
  logic [5:0]  randIdx;

  always #2 clk = ~clk;

  seg_tlb uut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  bit mV[64], mG[64], mD[64], mN[64];
  int mAsid[64], mVpn[64], mPfn[64];
  int lfsr = 1;

  task automatic expect_out(input string tag, output logic [31:0] ePa, output bit eC,
                            output bit eMiss, output bit eMod, output bit eErr);
    bit xl;
    int hit;
    ePa = 0; eC = 0; eMiss = 0; eMod = 0; eErr = 0;
    xl = !lookupVa[31] || lookupVa[31:30] == 2'b11;
    if (userMode && lookupVa[31]) eErr = 1;
    else if (!xl) begin
      ePa = lookupVa & 32'h1FFF_FFFF;
      eC  = (lookupVa[31:29] == 3'b100);
    end else begin
      hit = -1;
      for (int e = 63; e >= 0; e--)
        if (mV[e] && mVpn[e] == int'(lookupVa[31:12]) && (mG[e] || mAsid[e] == int'(curAsid)))
          hit = e;
      if (hit < 0) eMiss = 1;
      else if (isStore && !mD[hit]) eMod = 1;
      else begin
        ePa = {mPfn[hit][19:0], lookupVa[11:0]};
        eC  = !mN[hit];
      end
    end
  endtask

  // compare at mid-cycle, then let one edge pass and update the model
  task automatic step(input string tag);
    logic [31:0] ePa;
    bit eC, eMiss, eMod, eErr;
    #1;
    expect_out(tag, ePa, eC, eMiss, eMod, eErr);
    checks++;
    if (physAddr !== ePa || cacheable !== eC || tlbMiss !== eMiss ||
        modFault !== eMod || addrErr !== eErr || randIdx !== 6'(lfsr)) begin
      fails++;
      $display("FAIL %s va=%h: pa=%h/%h c=%b/%b miss=%b/%b mod=%b/%b err=%b/%b rand=%0d/%0d",
               tag, lookupVa, physAddr, ePa, cacheable, eC, tlbMiss, eMiss,
               modFault, eMod, addrErr, eErr, randIdx, lfsr);
    end
    @(posedge clk);
    if (rstN) begin
      if (wrEn) begin
        mV[wrIdx] = wrValid; mG[wrIdx] = wrGlobal; mD[wrIdx] = wrDirty;
        mN[wrIdx] = wrNoCache; mAsid[wrIdx] = wrAsid;
        mVpn[wrIdx] = wrVpn; mPfn[wrIdx] = wrPfn;
      end
      lfsr = ((lfsr << 1) & 63) | (((lfsr >> 5) ^ (lfsr >> 4)) & 1);
    end
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input bit st,
                      input bit um, input string tag);
    lookupVa = va; curAsid = asid; isStore = st; userMode = um;
    step(tag);
  endtask

  task automatic wr(input int idx, input bit v, input bit g, input bit d, input bit n,
                    input logic [5:0] asid, input logic [19:0] vpn, input logic [19:0] pfn);
    wrEn = 1; wrIdx = 6'(idx); wrValid = v; wrGlobal = g; wrDirty = d;
    wrNoCache = n; wrAsid = asid; wrVpn = vpn; wrPfn = pfn;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: empty after reset, replacement index 1
    look(32'h0040_0ABC, 6'd3, 0, 1, "R1 reset miss");
    look(32'hC000_1010, 6'd3, 0, 0, "R1 R2 kernel mapped miss");
    // R3: direct regions
    look(32'h8000_1234, 6'd0, 0, 0, "R3 R2 direct cached");
    look(32'hA0AB_CDEF, 6'd0, 1, 0, "R3 R2 direct uncached");
    // R8, R4: write and hit
    wr(5, 1, 0, 1, 0, 6'd3, 20'h00400, 20'h12345);
    look(32'h0040_0ABC, 6'd3, 0, 1, "R8 write same-cycle still miss");
    look(32'h0040_0ABC, 6'd3, 1, 1, "R4 R8 user hit");
    look(32'h0040_0ABC, 6'd4, 0, 1, "R5 space number mismatch");
    // global, non-writeable, non-cacheable kernel mapped page
    wr(6, 1, 1, 0, 1, 6'd9, 20'hC0001, 20'h00777);
    look(32'h0000_0000, 6'd9, 0, 0, "R5 user page miss");
    look(32'hC000_1010, 6'd33, 0, 0, "R4 global load");
    look(32'hC000_1010, 6'd33, 1, 0, "R6 store to read-only");
    look(32'hC000_1010, 6'd33, 1, 1, "R7 R10 user to kernel mapped");
    look(32'h8000_0000, 6'd0, 0, 1, "R7 user to direct");
    // R8: overwrite entry 5
    wr(5, 1, 0, 1, 0, 6'd3, 20'h00500, 20'h0ABCD);
    look(32'h0000_0FFF, 6'd3, 0, 1, "R8 overwrite pending");
    look(32'h0040_0ABC, 6'd3, 0, 1, "R8 old page gone");
    look(32'h0050_0123, 6'd3, 1, 1, "R8 new page hits");
    // R3: direct region ignores a matching entry
    wr(7, 1, 1, 1, 1, 6'd0, 20'h80001, 20'h55555);
    look(32'h0050_0123, 6'd3, 0, 0, "R8 pending");
    look(32'h8000_1234, 6'd0, 0, 0, "R3 entry ignored in direct region");
    // invalidating write
    wr(6, 0, 1, 1, 0, 6'd9, 20'hC0001, 20'h00777);
    look(32'h8000_1234, 6'd0, 0, 0, "R3 pending");
    look(32'hC000_1010, 6'd9, 0, 0, "R8 R5 invalidated");
    // random traffic, page low bits tied to entry number
    for (int i = 0; i < 600; i++) begin
      int idx;
      logic [2:0] top;
      if ($urandom_range(0, 2) == 0) begin
        idx = (i % 3 == 0) ? int'(randIdx) : int'($urandom_range(0, 63));
        top = 3'($urandom);
        wr(idx, $urandom_range(0, 4) != 0, $urandom_range(0, 3) == 0, 1'($urandom),
           1'($urandom), 6'($urandom_range(0, 3)),
           {top, 10'd0, 1'($urandom), 6'(idx)}, 20'($urandom));
      end
      top = 3'($urandom);
      look({top, 10'd0, 1'($urandom), 6'($urandom), 12'($urandom)},
           6'($urandom_range(0, 3)), 1'($urandom), $urandom_range(0, 3) == 0,
           "R2 R4 R5 R6 R7 R9 R10 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule